// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A requester presents a virtual address together with the kind of access (load or store, privileged or user). The walker reads one first-level descriptor. Depending on that descriptor's type, it either finishes at once with a 1 MB section mapping or reads a second-level descriptor from a coarse table that maps 4 KB small pages.

Two configuration inputs shape every walk: the base address of the first-level table (16 KB aligned) and a 32-bit domain control word. The domain control word holds one 2-bit policy per domain for 16 domains. The walker first checks the domain policy of the mapping. For client domains it then checks the 2-bit access-permission field that applies. For a small page this field is one of four, picked by the 1 KB quarter of the page being accessed. The response reports the physical address, the cacheable and bufferable attributes and the pass-through TEX bits, or a 4-bit fault code.

The walker handles one translation at a time. Descriptors are read through a port that allows one read in flight. The read address is held until the memory accepts it, and the data or a read error comes back later. The configuration inputs must stay stable while a walk is in progress.

Top module: `xlat_walker`

## Requirements
- R1: The first memory read of a walk uses address `cfg_tbl_base | (vaddr[31:20] << 2)`. For example, base 0x4000 and virtual address 0x12345678 give a read at 0x448C.
- R2: A first-level descriptor with type bits [1:0] = 2'b10 is a section. The walk ends after that single read with physical address {desc[31:20], vaddr[19:0]}, cacheable = desc[3], bufferable = desc[2] and TEX = desc[14:12]. The domain is desc[8:5] and the permission field is desc[11:10].
- R3: A first-level descriptor with type bits 2'b01 points to a coarse table. The second read uses address {desc[31:10], 10'b0} | (vaddr[19:12] << 2).
- R4: A second-level descriptor with type bits 2'b10 is a small page with physical address {desc[31:12], vaddr[11:0]}, cacheable = desc[3], bufferable = desc[2] and TEX = 0. Its domain comes from the first-level descriptor bits [8:5].
- R5: A first-level type of 2'b00 or 2'b11 ends the walk with fault code 0x5 and no second read. A second-level type other than 2'b10 ends the walk with fault code 0x7.
- R6: The policy for domain d is `cfg_dom_ctrl[2d+1:2d]`. Policy 2'b00 (no access) or 2'b10 (reserved) gives a domain fault: code 0x9 for a section, 0xB for a small page. Policy 2'b11 (manager) skips the permission check. Policy 2'b01 (client) applies R7. A domain fault takes priority over a permission fault.
- R7: In a client domain the permission value is checked as follows. 2'b00 denies every access. 2'b01 allows privileged access only. 2'b10 gives privileged access in full and user access for reads only. 2'b11 allows everything. A violation gives code 0xD for a section and 0xF for a small page. For a small page, vaddr[11:10] selects the field at desc[5:4], [7:6], [9:8] or [11:10] for values 0, 1, 2, 3.
- R8: A read error on the first read ends the walk with code 0xC. A read error on the second read ends it with code 0xE.
- R9: `req_ready` is high when idle, goes low on the cycle after a request is accepted, and stays low until `rsp_valid` has pulsed for exactly one cycle. `rsp_valid` rises one cycle after the last descriptor returns. A pending memory read holds its address until it is accepted. `rsp_fault` is high with the pulse exactly when the fault code is non-zero; code 0 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = store access, 0 = load |
| req_priv | input | 1 | 1 = privileged access, 0 = user |
| cfg_tbl_base | input | 32 | First-level table base, 16 KB aligned |
| cfg_dom_ctrl | input | 32 | Sixteen 2-bit domain policies |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read failed (with mem_rsp_valid) |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_bufferable | output | 1 | Bufferable attribute |
| rsp_tex | output | 3 | Section TEX bits passed through |
| rsp_fault | output | 1 | Translation failed |
| rsp_fault_code | output | 4 | Fault reason, 0 when no fault |

## Verification
The first descriptor read is due on the cycle after acceptance. Each following read or the result follows exactly one edge after the previous descriptor word is returned. The bench therefore tracks each walk step by step: it holds off the read handshake one cycle to see the address stay put, returns data after a chosen latency, and requires `rsp_valid` on the very next falling-edge sample after the final word. It also checks that the number of reads matches the descriptor types and that `req_ready` is back one cycle after the pulse. All inputs change and all outputs are sampled on falling edges, so each result is compared in the cycle it is due.

// File: rtl/xw_pkg.sv
package xw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_RESP
   } xw_state_e;

   typedef enum logic [1:0] {
      DOM_DENY = 2'b00, DOM_CLIENT = 2'b01, DOM_RSVD = 2'b10, DOM_MANAGER = 2'b11
   } xw_dom_e;

   // descriptor type codes (bits 1:0)
   localparam logic [1:0] DT_COARSE  = 2'b01;
   localparam logic [1:0] DT_SECTION = 2'b10;
   localparam logic [1:0] DT_SMALL   = 2'b10;

   // descriptor field positions
   localparam int POS_B      = 2;
   localparam int POS_C      = 3;
   localparam int POS_DOM    = 5;
   localparam int POS_SUB_AP = 4;
   localparam int POS_SEC_AP = 10;
   localparam int POS_TEX    = 12;

   // fault codes
   localparam logic [3:0] FC_NONE      = 4'h0;
   localparam logic [3:0] FC_XLAT_SEC  = 4'h5;
   localparam logic [3:0] FC_XLAT_PAGE = 4'h7;
   localparam logic [3:0] FC_DOM_SEC   = 4'h9;
   localparam logic [3:0] FC_DOM_PAGE  = 4'hB;
   localparam logic [3:0] FC_EXT_L1    = 4'hC;
   localparam logic [3:0] FC_PERM_SEC  = 4'hD;
   localparam logic [3:0] FC_EXT_L2    = 4'hE;
   localparam logic [3:0] FC_PERM_PAGE = 4'hF;

endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen #(
   parameter int AW       = 32,
   parameter int L1_IDX_W = 12,
   parameter int L2_IDX_W = 8,
   parameter bit BASE_ADD = 1'b0,
   localparam int SEC_LSB  = AW - L1_IDX_W,
   localparam int PAGE_LSB = SEC_LSB - L2_IDX_W,
   localparam int CT_LSB   = L2_IDX_W + 2
) (
   input  logic [AW-1:0]     tbl_base,
   input  logic [AW-1:0]     vaddr,
   input  logic [AW-1:CT_LSB] coarse_base,
   input  logic              pick_l2,
   output logic [AW-1:0]     fetch_addr
);
   logic [AW-1:0] l1_off, l2_off, l1_addr, l2_addr, ct_base;

   assign l1_off  = {{(AW-L1_IDX_W-2){1'b0}}, vaddr[AW-1:SEC_LSB], 2'b00};
   assign l2_off  = {{(AW-L2_IDX_W-2){1'b0}}, vaddr[SEC_LSB-1:PAGE_LSB], 2'b00};
   assign ct_base = {coarse_base, {CT_LSB{1'b0}}};

   generate
      if (CT_LSB > SEC_LSB) begin : g_bad_split
         $error("xw_addr_gen: coarse index wider than section offset");
      end
      if (BASE_ADD) begin : g_add
         assign l1_addr = tbl_base + l1_off;
         assign l2_addr = ct_base + l2_off;
      end else begin : g_or
         assign l1_addr = tbl_base | l1_off;
         assign l2_addr = ct_base | l2_off;
      end
   endgenerate

   assign fetch_addr = pick_l2 ? l2_addr : l1_addr;
endmodule

// File: rtl/xw_perm_check.sv
module xw_perm_check
   import xw_pkg::*;
#(
   parameter int DOM_CNT = 16,
   localparam int DOM_W  = $clog2(DOM_CNT)
) (
   input  logic [2*DOM_CNT-1:0] dom_ctrl,
   input  logic [DOM_W-1:0]     dom,
   input  logic [1:0]           ap,
   input  logic                 is_write,
   input  logic                 is_priv,
   output logic                 dom_fault,
   output logic                 perm_fault
);
   xw_dom_e policy;
   logic    ap_ok;

   assign policy = xw_dom_e'(dom_ctrl[2*dom +: 2]);

   always_comb begin
      unique case (ap)
         2'b00:   ap_ok = 1'b0;
         2'b01:   ap_ok = is_priv;
         2'b10:   ap_ok = is_priv | ~is_write;
         default: ap_ok = 1'b1;
      endcase
   end

   assign dom_fault  = (policy == DOM_DENY) || (policy == DOM_RSVD);
   assign perm_fault = (policy == DOM_CLIENT) && !ap_ok;

   always_comb begin
      if (ap == 2'b11 && !dom_fault)
         AST_FULL_AP_PASSES: assert (!perm_fault); // R7
      if (ap != 2'b00 && is_priv && !is_write)
         AST_PRIV_READ_PASSES: assert (!perm_fault); // R7
   end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xw_pkg::*;
#(
   parameter int AW       = 32,
   parameter int L1_IDX_W = 12,
   parameter int L2_IDX_W = 8,
   parameter int DOM_CNT  = 16,
   parameter int SUBPAGES = 4,
   parameter bit BASE_ADD = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_vaddr,
   input  logic          req_write,
   input  logic          req_priv,
   input  logic [AW-1:0] cfg_tbl_base,
   input  logic [2*DOM_CNT-1:0] cfg_dom_ctrl,
   output logic          mem_req_valid,
   input  logic          mem_req_ready,
   output logic [AW-1:0] mem_req_addr,
   input  logic          mem_rsp_valid,
   input  logic [AW-1:0] mem_rsp_data,
   input  logic          mem_rsp_err,
   output logic          rsp_valid,
   output logic [AW-1:0] rsp_paddr,
   output logic          rsp_cacheable,
   output logic          rsp_bufferable,
   output logic [2:0]    rsp_tex,
   output logic          rsp_fault,
   output logic [3:0]    rsp_fault_code
);
   localparam int SEC_LSB  = AW - L1_IDX_W;
   localparam int PAGE_LSB = SEC_LSB - L2_IDX_W;
   localparam int CT_LSB   = L2_IDX_W + 2;
   localparam int DOM_W    = $clog2(DOM_CNT);
   localparam int SUB_W    = $clog2(SUBPAGES);

   generate
      if (AW != 32 || DOM_W != 4 || SUBPAGES != 4 || PAGE_LSB != 12) begin : g_bad_cfg
         $error("xlat_walker: descriptor layout needs 32-bit, 16 domains, 4 subpages, 4KB pages");
      end
   endgenerate

   xw_state_e            state_q;
   logic [AW-1:0]        va_q;
   logic                 wr_q, priv_q;
   logic [AW-1:CT_LSB]   ct_base_q;
   logic [DOM_W-1:0]     ct_dom_q;
   logic [AW-1:0]        pa_q;
   logic                 c_q, b_q;
   logic [2:0]           tex_q;
   logic [3:0]           code_q;

   logic                 in_l2;
   logic [DOM_W-1:0]     chk_dom;
   logic [1:0]           chk_ap;
   logic                 dom_fault, perm_fault;
   logic [1:0]           sub_ap [SUBPAGES];
   logic [1:0]           dtype;

   assign dtype = mem_rsp_data[1:0];
   assign in_l2 = (state_q == ST_L2_WAIT);

   for (genvar i = 0; i < SUBPAGES; i++) begin : g_sub_ap
      assign sub_ap[i] = mem_rsp_data[POS_SUB_AP + 2*i +: 2];
   end

   assign chk_dom = in_l2 ? ct_dom_q : mem_rsp_data[POS_DOM +: DOM_W];
   assign chk_ap  = in_l2 ? sub_ap[va_q[PAGE_LSB-1 -: SUB_W]]
                          : mem_rsp_data[POS_SEC_AP +: 2];

   xw_perm_check #(.DOM_CNT(DOM_CNT)) perm_i (
      .dom_ctrl   (cfg_dom_ctrl),
      .dom        (chk_dom),
      .ap         (chk_ap),
      .is_write   (wr_q),
      .is_priv    (priv_q),
      .dom_fault  (dom_fault),
      .perm_fault (perm_fault)
   );

   xw_addr_gen #(
      .AW(AW), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W), .BASE_ADD(BASE_ADD)
   ) addr_i (
      .tbl_base    (cfg_tbl_base),
      .vaddr       (va_q),
      .coarse_base (ct_base_q),
      .pick_l2     (state_q == ST_L2_REQ),
      .fetch_addr  (mem_req_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         va_q      <= '0;
         wr_q      <= 1'b0;
         priv_q    <= 1'b0;
         ct_base_q <= '0;
         ct_dom_q  <= '0;
         pa_q      <= '0;
         c_q       <= 1'b0;
         b_q       <= 1'b0;
         tex_q     <= '0;
         code_q    <= FC_NONE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               wr_q    <= req_write;
               priv_q  <= req_priv;
               state_q <= ST_L1_REQ;
            end
            ST_L1_REQ: if (mem_req_ready) state_q <= ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) begin
               state_q <= ST_RESP;
               if (mem_rsp_err) begin
                  code_q <= FC_EXT_L1;
               end else if (dtype == DT_SECTION) begin
                  pa_q   <= {mem_rsp_data[AW-1:SEC_LSB], va_q[SEC_LSB-1:0]};
                  c_q    <= mem_rsp_data[POS_C];
                  b_q    <= mem_rsp_data[POS_B];
                  tex_q  <= mem_rsp_data[POS_TEX +: 3];
                  code_q <= dom_fault  ? FC_DOM_SEC  :
                            perm_fault ? FC_PERM_SEC : FC_NONE;
               end else if (dtype == DT_COARSE) begin
                  ct_base_q <= mem_rsp_data[AW-1:CT_LSB];
                  ct_dom_q  <= mem_rsp_data[POS_DOM +: DOM_W];
                  state_q   <= ST_L2_REQ;
               end else begin
                  code_q <= FC_XLAT_SEC;
               end
            end
            ST_L2_REQ: if (mem_req_ready) state_q <= ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) begin
               state_q <= ST_RESP;
               if (mem_rsp_err) begin
                  code_q <= FC_EXT_L2;
               end else if (dtype == DT_SMALL) begin
                  pa_q   <= {mem_rsp_data[AW-1:PAGE_LSB], va_q[PAGE_LSB-1:0]};
                  c_q    <= mem_rsp_data[POS_C];
                  b_q    <= mem_rsp_data[POS_B];
                  tex_q  <= '0;
                  code_q <= dom_fault  ? FC_DOM_PAGE  :
                            perm_fault ? FC_PERM_PAGE : FC_NONE;
               end else begin
                  code_q <= FC_XLAT_PAGE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (state_q == ST_IDLE);
   assign mem_req_valid  = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
   assign rsp_valid      = (state_q == ST_RESP);
   assign rsp_paddr      = pa_q;
   assign rsp_cacheable  = c_q;
   assign rsp_bufferable = b_q;
   assign rsp_tex        = tex_q;
   assign rsp_fault_code = code_q;
   assign rsp_fault      = rsp_valid && (code_q != FC_NONE);

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready && !rsp_valid); // R9
   AST_RSP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready); // R9
   AST_MEM_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
   AST_SECTION_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_L1_WAIT && mem_rsp_valid && !mem_rsp_err && dtype == DT_SECTION
      |=> rsp_valid && !mem_req_valid); // R2
   AST_COARSE_SECOND_READ: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_L1_WAIT && mem_rsp_valid && !mem_rsp_err && dtype == DT_COARSE
      |=> mem_req_valid && !rsp_valid); // R3
   AST_L1_BAD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_L1_WAIT && mem_rsp_valid && !mem_rsp_err &&
      (dtype == 2'b00 || dtype == 2'b11)
      |=> rsp_valid && rsp_fault_code == FC_XLAT_SEC); // R5
   AST_READ_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_L1_WAIT || state_q == ST_L2_WAIT) && mem_rsp_valid && mem_rsp_err
      |=> rsp_valid && rsp_fault); // R8
endmodule

// File: tb/xlat_walker_tb_top.sv
module xlat_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0, cfg_tbl_base = '0, cfg_dom_ctrl = '0;
   logic        mem_req_valid, mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        rsp_valid, rsp_cacheable, rsp_bufferable, rsp_fault;
   logic [31:0] rsp_paddr;
   logic [2:0]  rsp_tex;
   logic [3:0]  rsp_fault_code;

   int checks = 0;
   int errors = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #10 clk = ~clk;

   xlat_walker dut_i (
      .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_write, .req_priv,
      .cfg_tbl_base, .cfg_dom_ctrl, .mem_req_valid, .mem_req_ready, .mem_req_addr,
      .mem_rsp_valid, .mem_rsp_data, .mem_rsp_err, .rsp_valid, .rsp_paddr,
      .rsp_cacheable, .rsp_bufferable, .rsp_tex, .rsp_fault, .rsp_fault_code
   );

   task automatic check(input bit ok, input string msg,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", msg, act, exp);
      end
   endtask

   task automatic rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
   endtask

   function automatic bit ap_allows(input logic [1:0] ap, input bit wr, input bit pv);
      case (ap)
         2'b00:   return 1'b0;
         2'b01:   return pv;
         2'b10:   return pv || !wr;
         default: return 1'b1;
      endcase
   endfunction

   // expected result computed from the requirements
   task automatic model(input logic [31:0] va, input bit wr, input bit pv,
                        input logic [31:0] d1, input logic [31:0] d2, input int err_lvl,
                        output logic [3:0] code, output logic [31:0] pa,
                        output logic [4:0] attr, output int nrd);
      logic [1:0] pol;
      logic [1:0] ap;
      pa = '0; attr = '0; code = 4'h0;
      pol = cfg_dom_ctrl[2*d1[8:5] +: 2];
      nrd = 1;
      if (err_lvl == 1) code = 4'hC;
      else if (d1[1:0] == 2'b10) begin
         pa   = {d1[31:20], va[19:0]};
         attr = {d1[3], d1[2], d1[14:12]};
         if (pol == 2'b00 || pol == 2'b10) code = 4'h9;
         else if (pol == 2'b01 && !ap_allows(d1[11:10], wr, pv)) code = 4'hD;
      end else if (d1[1:0] == 2'b01) begin
         nrd = 2;
         ap  = d2[4 + 2*va[11:10] +: 2];
         if (err_lvl == 2) code = 4'hE;
         else if (d2[1:0] != 2'b10) code = 4'h7;
         else begin
            pa   = {d2[31:12], va[11:0]};
            attr = {d2[3], d2[2], 3'b000};
            if (pol == 2'b00 || pol == 2'b10) code = 4'hB;
            else if (pol == 2'b01 && !ap_allows(ap, wr, pv)) code = 4'hF;
         end
      end else code = 4'h5;
   endtask

   task automatic do_walk(input logic [31:0] va, input bit wr, input bit pv,
                          input logic [31:0] d1, input logic [31:0] d2,
                          input int err_lvl, input int lat, input string tag);
      logic [3:0]  e_code;
      logic [31:0] e_pa, a0, a1, a2, e_a1, e_a2;
      logic [4:0]  e_attr;
      int          e_n, n, g;
      bit          seen, done;
      model(va, wr, pv, d1, d2, err_lvl, e_code, e_pa, e_attr, e_n);
      e_a1 = cfg_tbl_base | {18'd0, va[31:20], 2'b00};
      e_a2 = {d1[31:10], 10'd0} | {22'd0, va[19:12], 2'b00};
      a1 = '0; a2 = '0; a0 = '0;
      @(negedge clk);
      req_vaddr = va; req_write = wr; req_priv = pv; req_valid = 1'b1;
      check(req_ready === 1'b1, "R9 ready while idle", {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready === 1'b0, "R9 ready low after accept", {31'd0, req_ready}, 32'd0);
      n = 0; seen = 0; done = 0; g = 0;
      while (!done && g < 64) begin
         g++;
         if (mem_req_valid) begin
            if (!seen) begin
               seen = 1; a0 = mem_req_addr;
               @(negedge clk);
            end else begin
               check(mem_req_addr === a0, "R9 read address held", mem_req_addr, a0);
               if (n == 0) a1 = a0; else a2 = a0;
               mem_req_ready = 1'b1;
               @(negedge clk);
               mem_req_ready = 1'b0;
               repeat (lat) @(negedge clk);
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = (n == 0) ? d1 : d2;
               mem_rsp_err   = (err_lvl == n + 1);
               @(negedge clk);
               mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
               n++; seen = 0;
               if (n == e_n) begin
                  check(rsp_valid === 1'b1, {"R9 result one cycle after last word ", tag},
                        {31'd0, rsp_valid}, 32'd1);
                  done = 1;
               end
            end
         end else if (rsp_valid) begin
            done = 1;
         end else begin
            @(negedge clk);
         end
      end
      if (!done) check(1'b0, {"R9 walk never finished ", tag}, 32'(n), 32'(e_n));
      check(n == e_n, {"R3 R5 number of reads ", tag}, 32'(n), 32'(e_n));
      check(a1 === e_a1, "R1 first-level read address", a1, e_a1);
      if (e_n == 2) check(a2 === e_a2, "R3 second-level read address", a2, e_a2);
      check(rsp_fault_code === e_code, {"fault code ", tag}, {28'd0, rsp_fault_code}, {28'd0, e_code});
      check(rsp_fault === (e_code != 0), "R9 fault flag", {31'd0, rsp_fault}, {31'd0, e_code != 0});
      if (e_code == 0) begin
         check(rsp_paddr === e_pa, {"R2 R4 physical address ", tag}, rsp_paddr, e_pa);
         check({rsp_cacheable, rsp_bufferable, rsp_tex} === e_attr, {"R2 R4 attributes ", tag},
               {27'd0, rsp_cacheable, rsp_bufferable, rsp_tex}, {27'd0, e_attr});
      end
      @(negedge clk);
      check(rsp_valid === 1'b0 && req_ready === 1'b1, "R9 single pulse then ready",
            {30'd0, rsp_valid, req_ready}, 32'd1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd150000, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [31:0] d1, d2, va;
      logic [3:0]  dom;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
            "R9 reset state", {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);

      // R1 worked example
      cfg_tbl_base = 32'h0000_4000; cfg_dom_ctrl = 32'hFFFF_FFFF;
      do_walk(32'h1234_5678, 1'b0, 1'b1, 32'hABC0_0C0E, 32'd0, 0, 1, "R1 example");
      check(dut_i.mem_req_addr !== 32'hx, "R1 address defined", 32'd0, 32'd0);

      // R2 R6 R7 section sweep over policy, permission, access kind
      for (int pol = 0; pol < 4; pol++)
         for (int ap = 0; ap < 4; ap++)
            for (int k = 0; k < 4; k++) begin
               dom = 4'((pol * 5 + ap * 3 + k) % 16);
               rnd(); cfg_tbl_base = seed & 32'hFFFF_C000;
               rnd(); cfg_dom_ctrl = seed; cfg_dom_ctrl[2*dom +: 2] = 2'(pol);
               rnd(); d1 = seed; d1[1:0] = 2'b10; d1[8:5] = dom; d1[11:10] = 2'(ap);
               rnd(); va = seed;
               do_walk(va, k[0], k[1], d1, 32'd0, 0, k % 3, "R2 R6 R7 section");
            end

      // R3 R4 R6 R7 small-page sweep including subpage selection
      for (int pol = 0; pol < 4; pol++)
         for (int sel = 0; sel < 4; sel++)
            for (int ap = 0; ap < 4; ap++)
               for (int k = 0; k < 4; k++) begin
                  dom = 4'((pol * 7 + sel + ap * 3 + k) % 16);
                  rnd(); cfg_tbl_base = seed & 32'hFFFF_C000;
                  rnd(); cfg_dom_ctrl = seed; cfg_dom_ctrl[2*dom +: 2] = 2'(pol);
                  rnd(); d1 = seed; d1[1:0] = 2'b01; d1[8:5] = dom;
                  rnd(); d2 = seed; d2[1:0] = 2'b10; d2[4 + 2*sel +: 2] = 2'(ap);
                  rnd(); va = seed; va[11:10] = 2'(sel);
                  do_walk(va, k[0], k[1], d1, d2, 0, (sel + k) % 3, "R4 R6 R7 small page");
               end

      // R5 descriptor type sweep at both levels
      cfg_dom_ctrl = 32'hFFFF_FFFF;
      for (int t1 = 0; t1 < 4; t1++)
         for (int t2 = 0; t2 < 4; t2++) begin
            rnd(); cfg_tbl_base = seed & 32'hFFFF_C000;
            rnd(); d1 = seed; d1[1:0] = 2'(t1);
            rnd(); d2 = seed; d2[1:0] = 2'(t2);
            rnd(); va = seed;
            do_walk(va, 1'b1, 1'b0, d1, d2, 0, 0, "R5 descriptor types");
         end

      // R8 read errors at each level
      for (int t = 0; t < 4; t++) begin
         rnd(); cfg_tbl_base = seed & 32'hFFFF_C000;
         rnd(); d1 = seed; d1[1:0] = (t == 0) ? 2'b10 : 2'b01;
         rnd(); d2 = seed; d2[1:0] = 2'b10;
         rnd(); va = seed;
         do_walk(va, 1'b0, 1'b1, d1, d2, (t < 2) ? 1 : 2, t, "R8 read error");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule